// File: doc/BRIEF.md
# Ready-Gated System Clock Source Selector

This control block decides which of four oscillator sources drives the system clock. Software writes a requested source code, and for the high-speed external path it also writes a halve-rate bit. The block watches one ready flag per source. It moves its registered current-source code to the request only in a cycle where the requested source reports ready. A request to a source that is not yet ready stays pending. It completes without further software action as soon as that source becomes ready. A newer request overwrites an older one that is still waiting.

The block also owns the per-source enable bits. Software may write them freely, but it cannot clear the bit of a source that feeds the system clock, either directly or as the reference of the PLL. A wake-from-standby event overrides everything else: it returns the selection to the low-power internal oscillator and discards any pending request. Status outputs give a registered copy of the ready flags, the in-use mask, a pending bit and a one-cycle completion pulse. All logic runs in a single control clock domain. The glitch-free clock multiplexer itself sits outside this block.

Top module: `sysclk_sel`

## Requirements
- R1: After reset the outputs are as follows: cur_src is 00, cur_hdiv is 0, sw_pend is 0, switch_done is 0, rdy_stat is 0000 and src_en is 0001 (only the internal multi-speed oscillator is enabled).
- R2: Source codes are 00 for the multi-speed internal oscillator, 01 for the 16 MHz internal oscillator, 10 for the 32 MHz external oscillator and 11 for the PLL R output. A write with req_we stores req_src and req_hdiv. sw_pend is high whenever the stored code or halve bit differs from cur_src or cur_hdiv, and it is low in the cycle in which a commit appears.
- R3: cur_src changes, other than through a wakeup, only at an edge where src_rdy[requested code] was high.
- R4: A stored request whose source was not ready commits at the first edge where that source's src_rdy bit is high and req_we is low, with no further write.
- R5: switch_done is high for exactly the one cycle in which a committed change first shows on cur_src and cur_hdiv. A wakeup never raises it.
- R6: A write made while a request is pending replaces that request. A commit is never taken in a cycle that has req_we high.
- R7: cur_hdiv takes the stored halve bit only at a commit. A wakeup clears it to 0.
- R8: src_en bit i follows en_wdata[i] on en_we, except that it is held at 1 for any source that is in use after that edge.
- R9: wake returns cur_src to 00 and the stored request to 00 with halve bit 0 at the next edge. It takes priority over req_we and over a pending commit.
- R10: rdy_stat equals src_rdy delayed by one clock.
- R11: in_use has bit cur_src set. When cur_src is 11 it also has bit pll_ref set, provided pll_ref is not 11 (11 means no reference).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_we | input | 1 | Write strobe for the source request |
| req_src | input | 2 | Requested source code |
| req_hdiv | input | 1 | Requested halve-rate bit for the external path |
| en_we | input | 1 | Write strobe for the enable bits |
| en_wdata | input | 4 | Requested enable bit per source |
| src_rdy | input | 4 | Ready flag per source |
| pll_ref | input | 2 | Source feeding the PLL (11 = none) |
| wake | input | 1 | Wake-from-standby event |
| cur_src | output | 2 | Registered current source code |
| cur_hdiv | output | 1 | Halve-rate bit in effect |
| sw_pend | output | 1 | Request differs from current selection |
| switch_done | output | 1 | One-cycle commit pulse |
| src_en | output | 4 | Enable bit per source |
| in_use | output | 4 | Sources currently feeding the system clock |
| rdy_stat | output | 4 | Registered ready flags |

## Verification
Directed sequences cover four cases. In the first, a request goes to a source whose ready flag is low and rises later; this separates an immediate commit from a deferred one. In the second, a request is replaced before its source is ready; this separates keeping the newest request from keeping the first one. In the third, disable writes are aimed at the current source and at the PLL reference while the PLL is selected; this shows whether protection covers both. In the fourth, a wakeup coincides with a write and with a ready commit; this confirms the priority order. Random cycles then mix requests, halve bits, enable writes, ready patterns and rare wakeups, and compare every output each cycle against a bench model built from the requirements.

// File: rtl/sysclk_sel_pkg.sv
// Shared constants and helpers for the system clock source selector.
// Assumes four sources with a two-bit code; the PLL reference code equal
// to the PLL code itself means "no reference".
package sysclk_sel_pkg;

    localparam int unsigned NSRC   = 4;
    localparam int unsigned CODE_W = $clog2(NSRC);

    typedef enum logic [CODE_W-1:0] {
        SRC_MSI = CODE_W'(0),
        SRC_HSI = CODE_W'(1),
        SRC_HSE = CODE_W'(2),
        SRC_PLL = CODE_W'(3)
    } src_code_e;

    // Mask of sources that must keep running when 'code' drives the system clock.
    function automatic logic [NSRC-1:0] use_mask(
        input logic [CODE_W-1:0] code,
        input logic [CODE_W-1:0] pll_ref
    );
        logic [NSRC-1:0] m;
        m = '0;
        m[code] = 1'b1;
        if (code == SRC_PLL && pll_ref != SRC_PLL) begin
            m[pll_ref] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sysclk_req_hold.sv
// Holds the most recent source request written by software.
// Assumes: a wakeup overrides a same-cycle write and returns the request
// to the reset source with the halve bit cleared.
module sysclk_req_hold #(
    parameter int unsigned CODE_W   = 2,
    parameter logic [CODE_W-1:0] RST_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_hdiv,
    output logic [CODE_W-1:0] req_code,
    output logic              req_hdiv
);

    logic [CODE_W-1:0] code_q;
    logic              hdiv_q;

    // Request register: wakeup first, then a software write replaces any older request.
    always_ff @(posedge clk) begin
        if (!rst_n || wake) begin
            code_q <= RST_CODE;
            hdiv_q <= 1'b0;
        end else if (wr_en) begin
            code_q <= wr_code;
            hdiv_q <= wr_hdiv;
        end
    end

    assign req_code = code_q;
    assign req_hdiv = hdiv_q;

endmodule

// File: rtl/sysclk_commit.sv
// Commits a stored request to the current-source register once the
// requested source is ready. Assumes the ready flags are synchronous to clk.
// A cycle with a request write never commits, so the newest request wins.
module sysclk_commit #(
    parameter int unsigned N_SRC  = 4,
    parameter int unsigned CODE_W = 2,
    parameter logic [CODE_W-1:0] RST_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake,
    input  logic              req_wr,
    input  logic [CODE_W-1:0] req_code,
    input  logic              req_hdiv,
    input  logic [N_SRC-1:0]  src_rdy,
    output logic [CODE_W-1:0] cur_code,
    output logic              cur_hdiv,
    output logic              pend,
    output logic              done_pulse,
    output logic [CODE_W-1:0] nxt_code
);

    logic [CODE_W-1:0] cur_q;
    logic              hdiv_q;
    logic              done_q;
    logic              take;
    logic              nxt_hdiv;

    // Decide the selection for the next cycle: wakeup, commit, or hold.
    always_comb begin
        pend = (req_code != cur_q) || (req_hdiv != hdiv_q);
        take = pend && !req_wr && src_rdy[req_code];
        if (wake) begin
            nxt_code = RST_CODE;
            nxt_hdiv = 1'b0;
        end else if (take) begin
            nxt_code = req_code;
            nxt_hdiv = req_hdiv;
        end else begin
            nxt_code = cur_q;
            nxt_hdiv = hdiv_q;
        end
    end

    // Selection register with its one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= RST_CODE;
            hdiv_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            cur_q  <= nxt_code;
            hdiv_q <= nxt_hdiv;
            done_q <= take && !wake;
        end
    end

    assign cur_code   = cur_q;
    assign cur_hdiv   = hdiv_q;
    assign done_pulse = done_q;

endmodule

// File: rtl/sysclk_en_guard.sv
// Per-source enable bits with protection: a bit in keep_mask is forced
// to 1 regardless of what software writes. Assumes keep_mask already
// describes the selection that holds after the coming edge.
module sysclk_en_guard #(
    parameter int unsigned N_SRC = 4,
    parameter logic [N_SRC-1:0] RST_EN = N_SRC'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N_SRC-1:0] wr_data,
    input  logic [N_SRC-1:0] keep_mask,
    output logic [N_SRC-1:0] en
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        logic bit_q;

        // One enable cell: take the software value, then apply the keep-alive force.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= RST_EN[i];
            end else begin
                bit_q <= (wr_en ? wr_data[i] : bit_q) | keep_mask[i];
            end
        end

        assign en[i] = bit_q;
    end

endmodule

// File: rtl/sysclk_sel.sv
// Ready-gated system clock source selector. Holds a software request,
// commits it when the target source is ready, guards enable bits of
// sources in use and reports status. Single clock domain, synchronous
// active-low reset.
module sysclk_sel #(
    parameter int unsigned N_SRC = sysclk_sel_pkg::NSRC
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_we,
    input  logic [sysclk_sel_pkg::CODE_W-1:0]   req_src,
    input  logic                                req_hdiv,
    input  logic                                en_we,
    input  logic [N_SRC-1:0]                    en_wdata,
    input  logic [N_SRC-1:0]                    src_rdy,
    input  logic [sysclk_sel_pkg::CODE_W-1:0]   pll_ref,
    input  logic                                wake,
    output logic [sysclk_sel_pkg::CODE_W-1:0]   cur_src,
    output logic                                cur_hdiv,
    output logic                                sw_pend,
    output logic                                switch_done,
    output logic [N_SRC-1:0]                    src_en,
    output logic [N_SRC-1:0]                    in_use,
    output logic [N_SRC-1:0]                    rdy_stat
);

    import sysclk_sel_pkg::*;

    localparam int unsigned W = CODE_W;
    localparam logic [W-1:0] RST_CODE = SRC_MSI;
    localparam logic [N_SRC-1:0] RST_EN = N_SRC'(1) << RST_CODE;

    logic [W-1:0]     req_code_w;
    logic             req_hdiv_w;
    logic [W-1:0]     nxt_code_w;
    logic [N_SRC-1:0] keep_w;
    logic [N_SRC-1:0] rdy_q;

    sysclk_req_hold #(.CODE_W(W), .RST_CODE(RST_CODE)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake     (wake),
        .wr_en    (req_we),
        .wr_code  (req_src),
        .wr_hdiv  (req_hdiv),
        .req_code (req_code_w),
        .req_hdiv (req_hdiv_w)
    );

    sysclk_commit #(.N_SRC(N_SRC), .CODE_W(W), .RST_CODE(RST_CODE)) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake       (wake),
        .req_wr     (req_we),
        .req_code   (req_code_w),
        .req_hdiv   (req_hdiv_w),
        .src_rdy    (src_rdy),
        .cur_code   (cur_src),
        .cur_hdiv   (cur_hdiv),
        .pend       (sw_pend),
        .done_pulse (switch_done),
        .nxt_code   (nxt_code_w)
    );

    // Keep-alive mask for the selection that holds after the coming edge.
    always_comb begin
        keep_w = use_mask(nxt_code_w, pll_ref);
    end

    sysclk_en_guard #(.N_SRC(N_SRC), .RST_EN(RST_EN)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (en_we),
        .wr_data   (en_wdata),
        .keep_mask (keep_w),
        .en        (src_en)
    );

    // Ready status register: one-cycle registered copy of the ready flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= '0;
        end else begin
            rdy_q <= src_rdy;
        end
    end

    assign rdy_stat = rdy_q;

    // In-use report for the present selection.
    always_comb begin
        in_use = use_mask(cur_src, pll_ref);
    end

endmodule

// File: rtl/sysclk_sel_chk.sv
// Property checker for the system clock source selector, bound to the top.
// Observes ports plus the stored request inside the top.
module sysclk_sel_chk #(
    parameter int unsigned N_SRC  = 4,
    parameter int unsigned CODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_we,
    input logic [CODE_W-1:0] req_src,
    input logic              wake,
    input logic [N_SRC-1:0]  src_rdy,
    input logic [CODE_W-1:0] cur_src,
    input logic              cur_hdiv,
    input logic              sw_pend,
    input logic              switch_done,
    input logic [N_SRC-1:0]  src_en,
    input logic [N_SRC-1:0]  in_use,
    input logic [N_SRC-1:0]  rdy_stat,
    input logic [CODE_W-1:0] req_code,
    input logic              req_hdiv
);

    logic [N_SRC-1:0] rdy_prev;

    // Previous-cycle ready flags, for the commit check.
    always_ff @(posedge clk) begin
        rdy_prev <= src_rdy;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cur_src == '0 && !switch_done && !cur_hdiv && src_en == N_SRC'(1)));

    p_done_not_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        switch_done |-> !sw_pend);

    p_commit_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_src != $past(cur_src) && !$past(wake)) |-> rdy_prev[cur_src]);

    p_auto_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_pend && src_rdy[req_code] && !wake && !req_we) |=> switch_done);

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        switch_done |=> !switch_done);

    p_newest_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_we && !wake) |=> (req_code == $past(req_src)));

    p_hdiv_with_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_hdiv) |-> (switch_done || $past(wake)));

    p_current_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        src_en[cur_src]);

    p_wake_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (cur_src == '0 && !sw_pend && !switch_done && !req_hdiv));

    p_ready_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rdy_stat == $past(src_rdy)));

    p_in_use_current_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_use[cur_src]);

endmodule

bind sysclk_sel sysclk_sel_chk #(.N_SRC(N_SRC), .CODE_W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_we      (req_we),
    .req_src     (req_src),
    .wake        (wake),
    .src_rdy     (src_rdy),
    .cur_src     (cur_src),
    .cur_hdiv    (cur_hdiv),
    .sw_pend     (sw_pend),
    .switch_done (switch_done),
    .src_en      (src_en),
    .in_use      (in_use),
    .rdy_stat    (rdy_stat),
    .req_code    (req_code_w),
    .req_hdiv    (req_hdiv_w)
);

// File: tb/sysclk_sel_test.sv
// Bench for the system clock source selector: directed corner cases, then
// seeded random cycles, each cycle compared against a requirement model.
module sysclk_sel_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_we, req_hdiv, en_we, wake;
    logic [1:0] req_src, pll_ref;
    logic [3:0] en_wdata, src_rdy;
    logic [1:0] cur_src;
    logic       cur_hdiv, sw_pend, switch_done;
    logic [3:0] src_en, in_use, rdy_stat;

    always #2 clk = ~clk;

    sysclk_sel uut (
        .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_src(req_src),
        .req_hdiv(req_hdiv), .en_we(en_we), .en_wdata(en_wdata),
        .src_rdy(src_rdy), .pll_ref(pll_ref), .wake(wake),
        .cur_src(cur_src), .cur_hdiv(cur_hdiv), .sw_pend(sw_pend),
        .switch_done(switch_done), .src_en(src_en), .in_use(in_use),
        .rdy_stat(rdy_stat)
    );

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          finished = 0;

    // Model state, written from the requirements.
    logic [1:0] m_cur = 2'd0, m_req = 2'd0;
    logic       m_hdiv = 1'b0, m_rh = 1'b0, m_done = 1'b0;
    logic [3:0] m_en = 4'b0001, m_rdy = 4'b0000;

    // R11: current source bit, plus the PLL reference when the PLL (11) is current.
    function automatic logic [3:0] exp_use(logic [1:0] c, logic [1:0] p);
        logic [3:0] m;
        m = 4'b0001 << c;
        if (c == 2'd3 && p != 2'd3) m = m | (4'b0001 << p);
        return m;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3", "cur_src", cur_src, m_cur);
        chk("R7", "cur_hdiv", cur_hdiv, m_hdiv);
        chk("R2", "sw_pend", sw_pend, (m_req != m_cur) || (m_rh != m_hdiv));
        chk("R5", "switch_done", switch_done, m_done);
        chk("R8", "src_en", src_en, m_en);
        chk("R10", "rdy_stat", rdy_stat, m_rdy);
        chk("R11", "in_use", in_use, exp_use(m_cur, pll_ref));
    endtask

    // One cycle: drive at the falling edge, predict, then compare after the rising edge.
    task automatic step(logic w, logic rwe, logic [1:0] rs, logic rh,
                        logic ewe, logic [3:0] ed, logic [3:0] rdy, logic [1:0] pref);
        logic [1:0] n_cur, n_req;
        logic       n_hdiv, n_rh, n_done, pend, commit;
        logic [3:0] n_en;
        @(negedge clk);
        wake = w; req_we = rwe; req_src = rs; req_hdiv = rh;
        en_we = ewe; en_wdata = ed; src_rdy = rdy; pll_ref = pref;
        pend = (m_req != m_cur) || (m_rh != m_hdiv);
        if (w) begin                                   // R9
            n_cur = 2'd0; n_hdiv = 1'b0; n_req = 2'd0; n_rh = 1'b0; n_done = 1'b0;
        end else begin
            commit = pend && !rwe && rdy[m_req];         // R3, R4, R6
            n_cur  = commit ? m_req : m_cur;
            n_hdiv = commit ? m_rh : m_hdiv;             // R7
            n_done = commit;                             // R5
            n_req  = rwe ? rs : m_req;
            n_rh   = rwe ? rh : m_rh;
        end
        n_en = (ewe ? ed : m_en) | exp_use(n_cur, pref); // R8
        @(posedge clk);
        #1;
        m_cur = n_cur; m_hdiv = n_hdiv; m_req = n_req; m_rh = n_rh;
        m_done = n_done; m_en = n_en; m_rdy = rdy;
        compare_all();
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4127));
        rst_n = 1'b0; wake = 0; req_we = 0; req_src = 0; req_hdiv = 0;
        en_we = 0; en_wdata = 0; src_rdy = 4'b1111; pll_ref = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "cur_src", cur_src, 0);
        chk("R1", "src_en", src_en, 4'b0001);
        chk("R1", "sw_pend/done/hdiv", {sw_pend, switch_done, cur_hdiv}, 0);
        chk("R1", "rdy_stat", rdy_stat, 0);

        // R4: request HSE (10) while not ready, commit when its ready flag rises.
        step(0, 1, 2'd2, 0, 1, 4'b0101, 4'b0001, 2'd3);
        step(0, 0, 2'd0, 0, 0, 4'b0000, 4'b0001, 2'd3);
        step(0, 0, 2'd0, 0, 0, 4'b0000, 4'b0011, 2'd3);
        chk("R4", "still pending", {sw_pend, cur_src}, {1'b1, 2'd0});
        step(0, 0, 2'd0, 0, 0, 4'b0000, 4'b0101, 2'd3);
        chk("R4", "auto commit", {switch_done, cur_src}, {1'b1, 2'd2});

        // R6: request HSI (01), replace with PLL (11) before HSI is ready.
        step(0, 1, 2'd1, 0, 0, 4'b0000, 4'b0100, 2'd3);
        step(0, 1, 2'd3, 0, 0, 4'b0000, 4'b0100, 2'd2);
        step(0, 0, 2'd0, 0, 0, 4'b0000, 4'b0110, 2'd2);
        chk("R6", "older request dropped", cur_src, 2'd2);
        step(0, 0, 2'd0, 0, 0, 4'b0000, 4'b1100, 2'd2);
        chk("R6", "newer request taken", cur_src, 2'd3);

        // R8, R11: PLL current with HSE reference; disabling all keeps both.
        step(0, 0, 2'd0, 0, 1, 4'b0000, 4'b1100, 2'd2);
        chk("R8", "protected enables", src_en, 4'b1100);
        chk("R11", "in_use with reference", in_use, 4'b1100);

        // R7: HSE at half rate.
        step(0, 1, 2'd2, 1, 0, 4'b0000, 4'b1100, 2'd2);
        step(0, 0, 2'd0, 0, 0, 4'b0000, 4'b1100, 2'd2);
        chk("R7", "halve bit latched", {cur_src, cur_hdiv}, {2'd2, 1'b1});

        // R9: wakeup together with a write and a ready target.
        step(0, 1, 2'd1, 0, 0, 4'b0000, 4'b0000, 2'd3);
        step(1, 1, 2'd3, 1, 0, 4'b0000, 4'b1111, 2'd3);
        chk("R9", "wake wins", {cur_src, cur_hdiv, sw_pend, switch_done}, 0);

        // Random traffic across all requirements.
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 40) == 0, ($urandom % 4) == 0, 2'($urandom),
                 1'($urandom), ($urandom % 8) == 0, 4'($urandom),
                 4'($urandom), 2'($urandom));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule